// File: doc/BRIEF.md
# Packed SIMD Multiply Unit

This block is a pipelined multiplier with one datapath for several operations. Each cycle it can take two 32-bit operands that have already been read, an operation code and a signedness control. Two clock edges later it returns the result as a low word and a high word, together with a valid flag. The unit does a full 32x32 multiply, two 16x16 lane multiplies, four 8x8 byte-lane multiplies, a four-lane byte dot product and a 16-bit complex multiply. The complex multiply has a wide form and a rounded packed form. The unit also multiplies four bytes in GF(2^8), using a reduction polynomial supplied on an input.

The first stage forms every partial product the operation might need. The 16x16 products are shared: the dual-lane mode and both complex modes take them from the same four half-word multipliers. The second stage combines, rounds, saturates and packs those products into the two result words, which are held in registers.

Top module: `simd_mul_unit`

## Requirements
- R1: When `in_valid` is high at a rising edge, `out_valid` is high after the second rising edge that follows, and the results for that operation appear in the same cycle. A new operation may be accepted on every edge.
- R2: Op code 0 (full multiply) returns the 64-bit product of `src_a` and `src_b`, low word on `res_lo` and high word on `res_hi`. The operands are two's complement when `is_signed` is 1 and unsigned when it is 0.
- R3: Op code 1 (dual half) multiplies bits [15:0] of the two operands and puts the 32-bit product on `res_lo`. It multiplies bits [31:16] and puts that product on `res_hi`. `is_signed` selects the signedness.
- R4: Op code 2 (quad byte) multiplies byte lane i of `src_a` by byte lane i of `src_b`, where lane i is bits [8i+7:8i]. Each 16-bit product goes to bits [16i+15:16i] of the 64-bit value {`res_hi`,`res_lo`}. `is_signed` selects the signedness.
- R5: Op code 3 (byte dot) returns on `res_lo` the sum of the four byte-lane products, each extended to 32 bits with the signedness given by `is_signed`. `res_hi` is 0.
- R6: Op code 4 (wide complex) reads bits [31:16] of each operand as the real part and bits [15:0] as the imaginary part, always signed. It returns re = ar*br - ai*bi on `res_lo` and im = ar*bi + ai*br on `res_hi`, each wrapped to 32 bits.
- R7: Op code 5 (rounded complex) adds 2^15 to the exact re and im, keeps bits [31:16] and saturates each to [-32768, 32767]. Rounded re goes to `res_lo[31:16]`, rounded im to `res_lo[15:0]`, and `res_hi` is 0.
- R8: Op code 6 (GF byte) multiplies each byte lane in GF(2^8). The low 8 bits of the reduction polynomial come from `gf_poly`, with x^8 implied. Lane i of the result goes to `res_lo[8i+7:8i]` and `res_hi` is 0.
- R9: While `rst_n` is low, `out_valid`, `res_lo` and `res_hi` are 0.
- R10: Op code 7 is reserved. An accepted op code 7 produces a valid result with both words 0.
- R11: When no operation completes in a cycle, `out_valid` is low and `res_lo` and `res_hi` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation presented this cycle |
| op_sel | input | 3 | Operation code (see requirements) |
| is_signed | input | 1 | Two's complement operands for op codes 0 to 3 |
| src_a | input | 32 | First operand |
| src_b | input | 32 | Second operand |
| gf_poly | input | 8 | GF(2^8) reduction polynomial, low 8 bits |
| out_valid | output | 1 | Result words are valid |
| res_lo | output | 32 | Low result word |
| res_hi | output | 32 | High result word |

## Verification
The bench builds the unit with its default lane widths: 32-bit words, two 16-bit lanes and four byte lanes. With those widths, hand-chosen operands can reach the extreme values. These include the product of two most-negative 32-bit values and the all-ones unsigned square. They also include the complex case where the imaginary sum reaches exactly 2^31, which wraps in the wide form and saturates in the rounded form. The GF lanes run under two polynomials, 0x1D and 0x1B, so a lane can be compared against a known field product. Back-to-back issue then shows that three different operations flow through the two stages without mixing.

// File: rtl/simd_mul_pkg.sv
package simd_mul_pkg;

    localparam int WORD_W  = 32;
    localparam int HALF_W  = WORD_W / 2;
    localparam int BYTE_W  = 8;
    localparam int N_BYTES = WORD_W / BYTE_W;

    typedef enum logic [2:0] {
        OP_MUL_FULL = 3'd0,
        OP_MUL_HALF = 3'd1,
        OP_MUL_BYTE = 3'd2,
        OP_DOT_BYTE = 3'd3,
        OP_CPX_WIDE = 3'd4,
        OP_CPX_RND  = 3'd5,
        OP_GF_BYTE  = 3'd6,
        OP_RSVD     = 3'd7
    } mul_op_e;

    typedef struct packed {
        logic                                 valid;
        logic                                 sgn;
        mul_op_e                              op;
        logic [2*WORD_W-1:0]                  p_full;
        logic [WORD_W-1:0]                    p_hh;   // a[31:16] * b[31:16]
        logic [WORD_W-1:0]                    p_ll;   // a[15:0]  * b[15:0]
        logic [WORD_W-1:0]                    p_hl;   // a[31:16] * b[15:0]
        logic [WORD_W-1:0]                    p_lh;   // a[15:0]  * b[31:16]
        logic [N_BYTES-1:0][2*BYTE_W-1:0]     p_byte;
        logic [N_BYTES-1:0][BYTE_W-1:0]       p_gf;
    } stage1_t;

endpackage

// File: rtl/gf8_lane_mul.sv
module gf8_lane_mul #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] poly,
    output logic [W-1:0] prod
);
    // Shift-and-add: the running multiple of a is reduced as it grows.
    always_comb begin
        logic [W-1:0] acc;
        logic [W-1:0] mult;
        acc  = '0;
        mult = a;
        for (int i = 0; i < W; i++) begin
            if (b[i]) acc = acc ^ mult;
            if (mult[W-1]) mult = (mult << 1) ^ poly;
            else           mult = mult << 1;
        end
        prod = acc;
    end
endmodule

// File: rtl/simd_mul_front.sv
module simd_mul_front
    import simd_mul_pkg::*;
(
    input  logic              in_valid,
    input  mul_op_e           op,
    input  logic              is_signed,
    input  logic [WORD_W-1:0] a,
    input  logic [WORD_W-1:0] b,
    input  logic [BYTE_W-1:0] poly,
    output stage1_t           nxt
);
    logic ext_half;
    logic signed [2*WORD_W+1:0] full_raw;

    // Both complex modes always treat the halves as signed.
    assign ext_half = is_signed || (op == OP_CPX_WIDE) || (op == OP_CPX_RND);

    function automatic logic [WORD_W-1:0] mul_half(input logic [HALF_W-1:0] x,
                                                   input logic [HALF_W-1:0] y,
                                                   input logic s);
        logic signed [WORD_W+1:0] p;
        p = $signed({s & x[HALF_W-1], x}) * $signed({s & y[HALF_W-1], y});
        return p[WORD_W-1:0];
    endfunction

    function automatic logic [2*BYTE_W-1:0] mul_byte(input logic [BYTE_W-1:0] x,
                                                     input logic [BYTE_W-1:0] y,
                                                     input logic s);
        logic signed [2*BYTE_W+1:0] p;
        p = $signed({s & x[BYTE_W-1], x}) * $signed({s & y[BYTE_W-1], y});
        return p[2*BYTE_W-1:0];
    endfunction

    assign full_raw = $signed({is_signed & a[WORD_W-1], a}) *
                      $signed({is_signed & b[WORD_W-1], b});

    assign nxt.valid  = in_valid;
    assign nxt.sgn    = is_signed;
    assign nxt.op     = op;
    assign nxt.p_full = full_raw[2*WORD_W-1:0];
    assign nxt.p_hh   = mul_half(a[WORD_W-1:HALF_W], b[WORD_W-1:HALF_W], ext_half);
    assign nxt.p_ll   = mul_half(a[HALF_W-1:0],      b[HALF_W-1:0],      ext_half);
    assign nxt.p_hl   = mul_half(a[WORD_W-1:HALF_W], b[HALF_W-1:0],      ext_half);
    assign nxt.p_lh   = mul_half(a[HALF_W-1:0],      b[WORD_W-1:HALF_W], ext_half);

    for (genvar g = 0; g < N_BYTES; g++) begin : g_lane
        assign nxt.p_byte[g] = mul_byte(a[g*BYTE_W +: BYTE_W], b[g*BYTE_W +: BYTE_W], is_signed);

        gf8_lane_mul #(.W(BYTE_W)) u_gf (
            .a    (a[g*BYTE_W +: BYTE_W]),
            .b    (b[g*BYTE_W +: BYTE_W]),
            .poly (poly),
            .prod (nxt.p_gf[g])
        );
    end
endmodule

// File: rtl/simd_mul_back.sv
module simd_mul_back
    import simd_mul_pkg::*;
(
    input  stage1_t           s1,
    output logic [WORD_W-1:0] lo,
    output logic [WORD_W-1:0] hi
);
    localparam logic signed [WORD_W+1:0] RND_BIAS = 34'sd32768;
    localparam int SUM_W = WORD_W + 1;

    logic signed [SUM_W-1:0] cpx_re;
    logic signed [SUM_W-1:0] cpx_im;
    logic [WORD_W-1:0]       dot_sum;

    assign cpx_re = $signed({s1.p_hh[WORD_W-1], s1.p_hh}) - $signed({s1.p_ll[WORD_W-1], s1.p_ll});
    assign cpx_im = $signed({s1.p_hl[WORD_W-1], s1.p_hl}) + $signed({s1.p_lh[WORD_W-1], s1.p_lh});

    function automatic logic [HALF_W-1:0] round_sat(input logic signed [SUM_W-1:0] v);
        logic signed [WORD_W+1:0]   t;
        logic signed [HALF_W+1:0]   q;
        t = $signed({v[SUM_W-1], v}) + RND_BIAS;
        q = t[WORD_W+1:HALF_W];
        if (q > 18'sd32767)       return 16'h7FFF;
        else if (q < -18'sd32768) return 16'h8000;
        else                      return q[HALF_W-1:0];
    endfunction

    always_comb begin
        dot_sum = '0;
        for (int i = 0; i < N_BYTES; i++) begin
            if (s1.sgn) dot_sum = dot_sum + {{(WORD_W-2*BYTE_W){s1.p_byte[i][2*BYTE_W-1]}}, s1.p_byte[i]};
            else        dot_sum = dot_sum + {{(WORD_W-2*BYTE_W){1'b0}}, s1.p_byte[i]};
        end
    end

    always_comb begin
        lo = '0;
        hi = '0;
        unique case (s1.op)
            OP_MUL_FULL: begin
                lo = s1.p_full[WORD_W-1:0];
                hi = s1.p_full[2*WORD_W-1:WORD_W];
            end
            OP_MUL_HALF: begin
                lo = s1.p_ll;
                hi = s1.p_hh;
            end
            OP_MUL_BYTE: begin
                lo = {s1.p_byte[1], s1.p_byte[0]};
                hi = {s1.p_byte[3], s1.p_byte[2]};
            end
            OP_DOT_BYTE: lo = dot_sum;
            OP_CPX_WIDE: begin
                lo = cpx_re[WORD_W-1:0];
                hi = cpx_im[WORD_W-1:0];
            end
            OP_CPX_RND:  lo = {round_sat(cpx_re), round_sat(cpx_im)};
            OP_GF_BYTE:  lo = s1.p_gf;
            OP_RSVD:     lo = '0;
            default:     lo = '0;
        endcase
    end
endmodule

// File: rtl/simd_mul_unit.sv
module simd_mul_unit
    import simd_mul_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [2:0]  op_sel,
    input  logic        is_signed,
    input  logic [31:0] src_a,
    input  logic [31:0] src_b,
    input  logic [7:0]  gf_poly,
    output logic        out_valid,
    output logic [31:0] res_lo,
    output logic [31:0] res_hi
);
    stage1_t           s1_d, s1_q;
    logic [WORD_W-1:0] lo_d, hi_d;

    simd_mul_front u_front (
        .in_valid  (in_valid),
        .op        (mul_op_e'(op_sel)),
        .is_signed (is_signed),
        .a         (src_a),
        .b         (src_b),
        .poly      (gf_poly),
        .nxt       (s1_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s1_q <= '0;
        else        s1_q <= s1_d;
    end

    simd_mul_back u_back (
        .s1 (s1_q),
        .lo (lo_d),
        .hi (hi_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            res_lo    <= '0;
            res_hi    <= '0;
        end else begin
            out_valid <= s1_q.valid;
            if (s1_q.valid) begin
                res_lo <= lo_d;
                res_hi <= hi_d;
            end
        end
    end
endmodule

// File: rtl/simd_mul_unit_chk.sv
module simd_mul_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [2:0]  op_sel,
    input logic        is_signed,
    input logic [31:0] src_a,
    input logic [31:0] src_b,
    input logic        out_valid,
    input logic [31:0] res_lo,
    input logic [31:0] res_hi
);
    logic [1:0] since_rst;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    // R9: results are cleared while reset is held
    always_comb begin
        if (!rst_n) begin
            a_r9_reset_clear: assert (!out_valid && res_lo == '0 && res_hi == '0);
        end
    end

    // R1: fixed two-edge latency from accept to valid
    a_r1_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2) |-> (out_valid == $past(in_valid, 2)));

    // R11: results hold when nothing completes
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2 && !$past(in_valid, 2)) |-> ($stable(res_lo) && $stable(res_hi)));

    // R2: full product over the two result words
    a_r2_full_product: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2 && $past(in_valid, 2) && $past(op_sel, 2) == 3'd0) |->
        ({res_hi, res_lo} == ($past(is_signed, 2)
            ? 64'($signed({{32{$past(src_a[31], 2)}}, $past(src_a, 2)}) * $signed({{32{$past(src_b[31], 2)}}, $past(src_b, 2)}))
            : 64'({32'd0, $past(src_a, 2)} * {32'd0, $past(src_b, 2)}))));

    // R5, R7, R8, R10: single-word modes leave the high word clear
    a_r5_single_word_hi: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && since_rst >= 2'd2 && $past(op_sel, 2) inside {3'd3, 3'd5, 3'd6, 3'd7}) |->
        (res_hi == '0));

    // R10: reserved op gives an all-zero result
    a_r10_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && since_rst >= 2'd2 && $past(op_sel, 2) == 3'd7) |-> (res_lo == '0));
endmodule

bind simd_mul_unit simd_mul_unit_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op_sel    (op_sel),
    .is_signed (is_signed),
    .src_a     (src_a),
    .src_b     (src_b),
    .out_valid (out_valid),
    .res_lo    (res_lo),
    .res_hi    (res_hi)
);

// File: tb/simd_mul_unit_test.sv
module simd_mul_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  op_sel = '0;
    logic        is_signed = 1'b0;
    logic [31:0] src_a = '0;
    logic [31:0] src_b = '0;
    logic [7:0]  gf_poly = 8'h1D;
    logic        out_valid;
    logic [31:0] res_lo, res_hi;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    simd_mul_unit uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
        .is_signed(is_signed), .src_a(src_a), .src_b(src_b), .gf_poly(gf_poly),
        .out_valid(out_valid), .res_lo(res_lo), .res_hi(res_hi)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // ---- reference models written from the requirements ----
    function automatic logic [63:0] ref_full(input logic [31:0] a, input logic [31:0] b, input logic s);
        longint sa, sb;
        if (s) begin
            sa = longint'($signed(a));
            sb = longint'($signed(b));
            return 64'(sa * sb);
        end
        return {32'd0, a} * {32'd0, b};
    endfunction

    function automatic logic [31:0] ref_half(input logic [15:0] a, input logic [15:0] b, input logic s);
        int x, y;
        x = s ? int'($signed(a)) : int'({16'd0, a});
        y = s ? int'($signed(b)) : int'({16'd0, b});
        return 32'(x * y);
    endfunction

    function automatic logic [15:0] ref_byte(input logic [7:0] a, input logic [7:0] b, input logic s);
        int x, y;
        x = s ? int'($signed(a)) : int'({24'd0, a});
        y = s ? int'($signed(b)) : int'({24'd0, b});
        return 16'(x * y);
    endfunction

    function automatic logic [7:0] ref_gf(input logic [7:0] a, input logic [7:0] b, input logic [7:0] p);
        logic [15:0] acc;
        acc = '0;
        for (int i = 0; i < 8; i++) if (b[i]) acc = acc ^ ({8'd0, a} << i);
        for (int k = 14; k >= 8; k--) if (acc[k]) acc = acc ^ ({7'd0, 1'b1, p} << (k - 8));
        return acc[7:0];
    endfunction

    function automatic logic [15:0] ref_rnd(input longint v);
        longint q;
        q = (v + 32768) >>> 16;
        if (q > 32767)  return 16'h7FFF;
        if (q < -32768) return 16'h8000;
        return 16'(q);
    endfunction

    function automatic logic [63:0] ref_op(input logic [2:0] op, input logic [31:0] a,
                                           input logic [31:0] b, input logic s, input logic [7:0] p);
        logic [63:0] r;
        longint ar, ai, br, bi, re, im, dsum;
        r = '0;
        ar = longint'($signed(a[31:16])); ai = longint'($signed(a[15:0]));
        br = longint'($signed(b[31:16])); bi = longint'($signed(b[15:0]));
        re = ar * br - ai * bi;
        im = ar * bi + ai * br;
        case (op)
            3'd0: r = ref_full(a, b, s);
            3'd1: r = {ref_half(a[31:16], b[31:16], s), ref_half(a[15:0], b[15:0], s)};
            3'd2: for (int i = 0; i < 4; i++) r[16*i +: 16] = ref_byte(a[8*i +: 8], b[8*i +: 8], s);
            3'd3: begin
                dsum = 0;
                for (int i = 0; i < 4; i++) begin
                    if (s) dsum = dsum + longint'($signed(ref_byte(a[8*i +: 8], b[8*i +: 8], s)));
                    else   dsum = dsum + longint'(ref_byte(a[8*i +: 8], b[8*i +: 8], s));
                end
                r = {32'd0, 32'(dsum)};
            end
            3'd4: r = {32'(im), 32'(re)};
            3'd5: r = {32'd0, ref_rnd(re), ref_rnd(im)};
            3'd6: for (int i = 0; i < 4; i++) r[8*i +: 8] = ref_gf(a[8*i +: 8], b[8*i +: 8], p);
            default: r = '0;
        endcase
        return r;
    endfunction

    // One operation: drive on a falling edge, sample two rising edges later.
    task automatic run_op(input string req, input logic [2:0] op, input logic [31:0] a,
                          input logic [31:0] b, input logic s, input logic [63:0] exp);
        @(negedge clk);
        in_valid = 1'b1; op_sel = op; src_a = a; src_b = b; is_signed = s;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        check({req, " valid"}, {63'd0, out_valid}, 64'd1);
        check(req, {res_hi, res_lo}, exp);
        check({req, " model"}, exp, ref_op(op, a, b, s, gf_poly));
    endtask

    task automatic t_reset;
        check("R9 reset state", {out_valid, res_hi, res_lo[30:0]}, 64'd0);
    endtask

    task automatic t_full;
        run_op("R2 unsigned all-ones", 3'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 64'hFFFF_FFFE_0000_0001);
        run_op("R2 signed -1*-1",      3'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 64'h0000_0000_0000_0001);
        run_op("R2 signed min*min",    3'd0, 32'h8000_0000, 32'h8000_0000, 1'b1, 64'h4000_0000_0000_0000);
        run_op("R2 signed mixed",      3'd0, 32'hFFFF_FFFE, 32'd3,         1'b1, 64'hFFFF_FFFF_FFFF_FFFA);
    endtask

    task automatic t_half;
        run_op("R3 signed lanes",   3'd1, 32'hFFFF_0003, 32'h0002_FFFB, 1'b1, {32'hFFFF_FFFE, 32'hFFFF_FFF1});
        run_op("R3 unsigned lanes", 3'd1, 32'hFFFF_0003, 32'h0002_FFFB, 1'b0, {32'h0001_FFFE, 32'h0002_FFF1});
    endtask

    task automatic t_byte;
        run_op("R4 signed bytes",   3'd2, 32'h80FF_0207, 32'h80FF_FD06, 1'b1, 64'h4000_0001_FFFA_002A);
        run_op("R4 unsigned bytes", 3'd2, 32'h80FF_0207, 32'h80FF_FD06, 1'b0, 64'h4000_FE01_01FA_002A);
    endtask

    task automatic t_dot;
        run_op("R5 signed dot",   3'd3, 32'h80FF_0207, 32'h80FF_FD06, 1'b1, {32'd0, 32'h0000_4025});
        run_op("R5 unsigned dot", 3'd3, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, {32'd0, 32'h0003_F804});
    endtask

    task automatic t_cpx;
        // (3+4j)*(5-2j) = 23 + 14j
        run_op("R6 wide complex",      3'd4, 32'h0003_0004, 32'h0005_FFFE, 1'b0, {32'd14, 32'd23});
        run_op("R6 wide imag wrap",    3'd4, 32'h8000_8000, 32'h8000_8000, 1'b0, {32'h8000_0000, 32'd0});
        run_op("R7 rounded saturate",  3'd5, 32'h8000_8000, 32'h8000_8000, 1'b0, {32'd0, 32'h0000_7FFF});
        // re = 0x4000*0x0002 - 0 = 0x8000 -> rounds up to 1; im = 0x4000*0x0001 = 0x4000 -> 0
        run_op("R7 rounded halfway",   3'd5, 32'h4000_0000, 32'h0002_0001, 1'b0, {32'd0, 32'h0001_0000});
        run_op("R7 rounded negative",  3'd5, 32'h8000_0000, 32'h7FFF_7FFF, 1'b0, {32'd0, 32'hC001_C001});
    endtask

    task automatic t_gf;
        gf_poly = 8'h1B;
        run_op("R8 gf poly 1B", 3'd6, 32'h5302_0100, 32'hCA87_FF37, 1'b0,
               {32'd0, ref_gf(8'h53, 8'hCA, 8'h1B), ref_gf(8'h02, 8'h87, 8'h1B), 8'hFF, 8'h00});
        check("R8 gf known lane", {56'd0, res_lo[31:24]}, 64'h01);
        gf_poly = 8'h1D;
        run_op("R8 gf poly 1D", 3'd6, 32'h8002_0100, 32'h0280_FF37, 1'b1, {32'd0, 8'h1D, 8'h1D, 8'hFF, 8'h00});
    endtask

    task automatic t_reserved;
        run_op("R10 reserved op", 3'd7, 32'h1234_5678, 32'h9ABC_DEF0, 1'b1, 64'd0);
    endtask

    task automatic t_hold;
        logic [63:0] prev;
        run_op("R11 setup", 3'd0, 32'd6, 32'd7, 1'b0, 64'd42);
        prev = {res_hi, res_lo};
        @(negedge clk);
        op_sel = 3'd1; src_a = 32'hFFFF_FFFF; src_b = 32'hFFFF_FFFF;
        repeat (3) @(negedge clk);
        check("R11 idle valid low", {63'd0, out_valid}, 64'd0);
        check("R11 idle hold",      {res_hi, res_lo}, prev);
    endtask

    task automatic t_back_to_back;
        @(negedge clk);
        in_valid = 1'b1; op_sel = 3'd0; src_a = 32'd1000; src_b = 32'd1000; is_signed = 1'b0;
        @(negedge clk);
        op_sel = 3'd2; src_a = 32'h0102_0304; src_b = 32'h0505_0505;
        @(negedge clk);
        check("R1 b2b first valid", {63'd0, out_valid}, 64'd1);
        check("R1 b2b first",  {res_hi, res_lo}, 64'd1000000);
        op_sel = 3'd3; src_a = 32'h0101_0101; src_b = 32'h0203_0405;
        @(negedge clk);
        in_valid = 1'b0;
        check("R1 b2b second", {res_hi, res_lo}, 64'h0005_000A_000F_0014);
        @(negedge clk);
        check("R1 b2b third",  {res_hi, res_lo}, 64'd14);
        check("R1 b2b third valid", {63'd0, out_valid}, 64'd1);
        @(negedge clk);
        check("R1 b2b drain", {63'd0, out_valid}, 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_full();
        t_half();
        t_byte();
        t_dot();
        t_cpx();
        t_gf();
        t_reserved();
        t_hold();
        t_back_to_back();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule